// File: doc/BRIEF.md
# Thresholded Event Counter with Overflow

This block is one slice of a performance-monitoring unit. Each cycle it picks one of several event input vectors, masks the bits of that vector, and counts how many masked bits are set. The result is a small per-cycle increment. A threshold stage can turn that increment into a single qualified event. An edge stage, placed after the threshold stage, can turn the qualified event into one count per rising edge. The result is added into a 48-bit counter.

Software programs the slice through a 32-bit control word and reads or preloads the counter through a 64-bit data view. Both are plain write-strobe and read-data ports, and the register-access fabric sits outside the block. To stop after N events, software preloads the counter with 2^48 - N. When the counter carries out of its top bit, it wraps and keeps counting. If overflow reporting is enabled, the slice also sets a sticky status flag and sends a one-cycle message pulse to a global unit outside the block.

Top module: `evcnt_slice`

## Requirements
- R1: After reset the counter reads 0, the control word reads 0, and both the overflow status and the overflow message are 0.
- R2: The control word holds threshold in bits 31:24, counter enable in bit 22, select extension in bit 21, overflow enable in bit 20, edge mode in bit 18, clear in bit 17, sub-event mask in 15:8 and event select in 7:0. Bits 23, 19, 17 and 16 always read 0, and the other fields read back as written.
- R3: The data view shows the 48-bit counter in bits 47:0. Bits 63:48 read 0 and ignore writes. A data write loads bits 47:0 into the counter at the next edge.
- R4: The event index is {extension, select}. An index below NUM_EVT picks input vector number index, which occupies bits index*EVT_W and up of evt_in. Any larger index gives increment 0. The increment is the number of set bits in the chosen vector ANDed with the sub-event mask.
- R5: With threshold 0 and edge mode 0, an enabled counter adds the raw increment in each cycle.
- R6: With a non-zero threshold and edge mode 0, an enabled counter adds 1 in each cycle whose increment is greater than or equal to the threshold, and adds 0 otherwise.
- R7: With edge mode 1 and a non-zero threshold, the counter adds 1 only in a cycle whose increment qualifies when the previous cycle's increment did not. With edge mode 1 and threshold 0, nothing is counted.
- R8: While the enable bit is 0, the counter keeps its value unless it is written or cleared.
- R9: A control write with bit 17 set zeroes the counter. This takes priority over a data write in the same cycle, and a data write takes priority over counting.
- R10: A carry out of bit 47 wraps the counter, which then keeps counting. If overflow enable is set at that time, the status flag is set and ovf_msg is high for exactly the cycle after that edge. Without overflow enable, neither the flag nor the message changes.
- R11: The status flag stays set until stat_clr is pulsed. If an overflow and stat_clr fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | NUM_EVT*EVT_W | Event input vectors, packed with index 0 in the low bits |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read data |
| data_wr | input | 1 | Counter preload strobe |
| data_wdata | input | DATA_W | Counter preload data |
| data_rdata | output | DATA_W | Counter read data |
| stat_clr | input | 1 | Clears the overflow status flag |
| ovf_status | output | 1 | Sticky overflow status |
| ovf_msg | output | 1 | One-cycle overflow message pulse |

## Verification
The assertions assume single-cycle write strobes that are sampled only at rising edges. They also assume that no two carries out of bit 47 happen in consecutive cycles, which holds because each step adds at most EVT_W. The stimulus changes inputs only on falling edges. Preloads close to the wrap point are directed, while the random phases keep the counter far from it. Random control words set the reserved bits freely, so the read-back masking is exercised on every control write.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
   localparam int CTL_W   = 32;
   localparam int THR_W   = 8;
   localparam int MASK_W  = 8;
   localparam int SEL_W   = 8;
   localparam int IDX_W   = SEL_W + 1;
   localparam int CLR_BIT = 17;

   typedef struct packed {
      logic [THR_W-1:0]  thresh;
      logic              en;
      logic              ext;
      logic              ov_en;
      logic              edge_m;
      logic [MASK_W-1:0] umask;
      logic [SEL_W-1:0]  sel;
   } evcnt_ctl_t;

   function automatic evcnt_ctl_t ctl_unpack(input logic [CTL_W-1:0] w);
      evcnt_ctl_t c;
      c.thresh = w[31:24];
      c.en     = w[22];
      c.ext    = w[21];
      c.ov_en  = w[20];
      c.edge_m = w[18];
      c.umask  = w[15:8];
      c.sel    = w[7:0];
      return c;
   endfunction

   function automatic logic [CTL_W-1:0] ctl_pack(input evcnt_ctl_t c);
      logic [CTL_W-1:0] w;
      w        = '0;
      w[31:24] = c.thresh;
      w[22]    = c.en;
      w[21]    = c.ext;
      w[20]    = c.ov_en;
      w[18]    = c.edge_m;
      w[15:8]  = c.umask;
      w[7:0]   = c.sel;
      return w;
   endfunction
endpackage

// File: rtl/evcnt_select.sv
module evcnt_select #(
   parameter int NUM_EVT = 4,
   parameter int EVT_W   = 8,
   parameter int IDX_W   = 9,
   parameter int MASK_W  = 8,
   localparam int INC_W  = $clog2(EVT_W + 1)
) (
   input  logic [NUM_EVT*EVT_W-1:0] evt_in,
   input  logic [IDX_W-1:0]         sel_idx,
   input  logic [MASK_W-1:0]        umask,
   output logic [INC_W-1:0]         inc
);
   generate
      if (EVT_W < 1 || EVT_W > MASK_W) begin : g_bad_evt_w
         $error("evcnt_select: EVT_W must lie in 1..MASK_W");
      end
      if (NUM_EVT < 1 || NUM_EVT > (1 << IDX_W)) begin : g_bad_num
         $error("evcnt_select: NUM_EVT out of range for IDX_W");
      end
   endgenerate

   logic [EVT_W-1:0] vec_a [NUM_EVT];
   logic [EVT_W-1:0] chosen;
   logic [EVT_W-1:0] masked;

   for (genvar g = 0; g < NUM_EVT; g++) begin : g_unpack
      assign vec_a[g] = evt_in[g*EVT_W +: EVT_W];
   end

   always_comb begin
      chosen = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         if (sel_idx == IDX_W'(i)) chosen = vec_a[i];
      end
   end

   assign masked = chosen & umask[EVT_W-1:0];

   always_comb begin
      inc = '0;
      for (int b = 0; b < EVT_W; b++) begin
         inc = inc + INC_W'(masked[b]);
      end
   end
endmodule

// File: rtl/evcnt_qualify.sv
module evcnt_qualify #(
   parameter int INC_W    = 4,
   parameter int THR_W    = 8,
   parameter bit HAS_EDGE = 1'b1,
   localparam int CMP_W   = (INC_W > THR_W) ? INC_W : THR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc,
   input  logic [THR_W-1:0] thresh,
   input  logic             edge_m,
   output logic [INC_W-1:0] add
);
   logic thr_on;
   logic qual;

   assign thr_on = (thresh != '0);
   assign qual   = thr_on && (CMP_W'(inc) >= CMP_W'(thresh));

   generate
      if (HAS_EDGE) begin : g_edge
         logic qual_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) qual_q <= 1'b0;
            else        qual_q <= qual;
         end
         always_comb begin
            if (edge_m)      add = INC_W'(qual && !qual_q);
            else if (thr_on) add = INC_W'(qual);
            else             add = inc;
         end
      end else begin : g_level
         always_comb begin
            if (thr_on) add = INC_W'(qual);
            else        add = inc;
         end
      end
   endgenerate

   // R6: a non-zero threshold turns the step into 0 or 1.
   p_unit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      thr_on |-> (add <= INC_W'(1)));
endmodule

// File: rtl/evcnt_accum.sv
module evcnt_accum #(
   parameter int CNT_W = 48,
   parameter int INC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ov_en,
   input  logic [INC_W-1:0] add,
   input  logic             clr,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             stat_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf_status,
   output logic             ovf_msg
);
   generate
      if (INC_W >= CNT_W) begin : g_bad_w
         $error("evcnt_accum: INC_W must be narrower than CNT_W");
      end
   endgenerate

   logic [CNT_W:0] sum;
   logic           ovf_hit;

   assign sum     = {1'b0, cnt} + (CNT_W+1)'(add);
   assign ovf_hit = en && !clr && !wr && sum[CNT_W] && ov_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt <= '0;
      else if (clr) cnt <= '0;
      else if (wr)  cnt <= wdata;
      else if (en)  cnt <= sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_msg    <= 1'b0;
         ovf_status <= 1'b0;
      end else begin
         ovf_msg    <= ovf_hit;
         ovf_status <= ovf_hit | (ovf_status & ~stat_clr);
      end
   end

   p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr && !wr) |=> $stable(cnt));
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   p_msg_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_msg |-> ovf_status);
   p_msg_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_msg |=> !ovf_msg);
   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_status && !stat_clr) |=> ovf_status);
endmodule

// File: rtl/evcnt_slice.sv
module evcnt_slice
   import evcnt_pkg::*;
#(
   parameter int NUM_EVT  = 4,
   parameter int EVT_W    = 8,
   parameter int CNT_W    = 48,
   parameter int DATA_W   = 64,
   parameter bit HAS_EDGE = 1'b1,
   localparam int INC_W   = $clog2(EVT_W + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_EVT*EVT_W-1:0] evt_in,
   input  logic                     ctl_wr,
   input  logic [31:0]              ctl_wdata,
   output logic [31:0]              ctl_rdata,
   input  logic                     data_wr,
   input  logic [DATA_W-1:0]        data_wdata,
   output logic [DATA_W-1:0]        data_rdata,
   input  logic                     stat_clr,
   output logic                     ovf_status,
   output logic                     ovf_msg
);
   generate
      if (CNT_W > DATA_W) begin : g_bad_data_w
         $error("evcnt_slice: CNT_W must not exceed DATA_W");
      end
   endgenerate

   evcnt_ctl_t       ctl_q;
   logic             clr_now;
   logic [INC_W-1:0] inc;
   logic [INC_W-1:0] add;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctl_unpack(ctl_wdata);
   end

   assign clr_now    = ctl_wr && ctl_wdata[CLR_BIT];
   assign ctl_rdata  = ctl_pack(ctl_q);
   assign data_rdata = DATA_W'(cnt);

   evcnt_select #(
      .NUM_EVT (NUM_EVT),
      .EVT_W   (EVT_W),
      .IDX_W   (IDX_W),
      .MASK_W  (MASK_W)
   ) sel_i (
      .evt_in  (evt_in),
      .sel_idx ({ctl_q.ext, ctl_q.sel}),
      .umask   (ctl_q.umask),
      .inc     (inc)
   );

   evcnt_qualify #(
      .INC_W    (INC_W),
      .THR_W    (THR_W),
      .HAS_EDGE (HAS_EDGE)
   ) qual_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc),
      .thresh (ctl_q.thresh),
      .edge_m (ctl_q.edge_m),
      .add    (add)
   );

   evcnt_accum #(
      .CNT_W (CNT_W),
      .INC_W (INC_W)
   ) acc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ctl_q.en),
      .ov_en      (ctl_q.ov_en),
      .add        (add),
      .clr        (clr_now),
      .wr         (data_wr),
      .wdata      (data_wdata[CNT_W-1:0]),
      .stat_clr   (stat_clr),
      .cnt        (cnt),
      .ovf_status (ovf_status),
      .ovf_msg    (ovf_msg)
   );

   p_preload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !clr_now) |=> (data_rdata[CNT_W-1:0] == $past(data_wdata[CNT_W-1:0])));
   p_clear_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_now |=> (data_rdata == '0));
endmodule

// File: tb/evcnt_slice_tb.sv
module evcnt_slice_tb_top;
   localparam int CLK_P   = 10;
   localparam int NUM_EVT = 4;
   localparam int EVT_W   = 8;
   localparam logic [31:0] WR_MASK = 32'hFF74_FFFF;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic [NUM_EVT*EVT_W-1:0] evt_in = '0;
   logic                     ctl_wr = 1'b0;
   logic [31:0]              ctl_wdata = '0;
   logic [31:0]              ctl_rdata;
   logic                     data_wr = 1'b0;
   logic [63:0]              data_wdata = '0;
   logic [63:0]              data_rdata;
   logic                     stat_clr = 1'b0;
   logic                     ovf_status;
   logic                     ovf_msg;

   int total = 0;
   int bad   = 0;
   string tag = "R1";

   logic [31:0] m_ctl = '0;
   logic [47:0] m_cnt = '0;
   logic        m_prev = 1'b0;
   logic        m_stat = 1'b0;
   logic        m_msg  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   evcnt_slice dut_i (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .data_wr(data_wr), .data_wdata(data_wdata), .data_rdata(data_rdata),
      .stat_clr(stat_clr), .ovf_status(ovf_status), .ovf_msg(ovf_msg)
   );

   function automatic int f_inc(input logic [31:0] ev, input logic [31:0] c);
      int idx = {c[21], c[7:0]};
      int n = 0;
      if (idx < NUM_EVT) begin
         for (int b = 0; b < EVT_W; b++) n += (ev[idx*EVT_W + b] & c[8+b]) ? 1 : 0;
      end
      return n;
   endfunction

   function automatic bit f_qual(input int inc, input logic [31:0] c);
      return (c[31:24] != 0) && (inc >= int'(c[31:24]));
   endfunction

   function automatic int f_add(input int inc, input logic [31:0] c, input bit prev);
      bit q = f_qual(inc, c);
      if (c[18]) return (q && !prev) ? 1 : 0;
      if (c[31:24] != 0) return q ? 1 : 0;
      return inc;
   endfunction

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      check("data", data_rdata, {16'h0, m_cnt});
      check("ctl", {32'h0, ctl_rdata}, {32'h0, m_ctl});
      check("status", {63'h0, ovf_status}, {63'h0, m_stat});
      check("msg", {63'h0, ovf_msg}, {63'h0, m_msg});
   endtask

   task automatic step(input logic [31:0] ev, input bit cw, input logic [31:0] cwd,
                       input bit dw, input logic [63:0] dwd, input bit sc);
      int inc, add;
      logic [48:0] sum;
      bit clr, hit;
      @(negedge clk);
      evt_in = ev; ctl_wr = cw; ctl_wdata = cwd;
      data_wr = dw; data_wdata = dwd; stat_clr = sc;
      inc = f_inc(ev, m_ctl);
      add = f_add(inc, m_ctl, m_prev);
      sum = {1'b0, m_cnt} + 49'(add);
      clr = cw && cwd[17];
      hit = m_ctl[22] && !clr && !dw && sum[48] && m_ctl[20];
      @(posedge clk);
      #1;
      m_prev = f_qual(inc, m_ctl);
      if (clr)            m_cnt = '0;
      else if (dw)        m_cnt = dwd[47:0];
      else if (m_ctl[22]) m_cnt = sum[47:0];
      m_stat = hit | (m_stat & ~sc);
      m_msg  = hit;
      if (cw) m_ctl = cwd & WR_MASK;
      check_all();
   endtask

   task automatic idle(input logic [31:0] ev);
      step(ev, 1'b0, 32'h0, 1'b0, 64'h0, 1'b0);
   endtask

   initial begin
      #(CLK_P * 200000);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      tag = "R1"; check_all();
      @(negedge clk); rst_n = 1'b1;
      idle(32'hFFFF_FFFF);

      // R2: reserved bits set in write data must read back as zero
      tag = "R2";
      step(32'h0, 1'b1, 32'hFFFF_FFFF, 1'b0, 64'h0, 1'b0);
      step(32'h0, 1'b1, 32'h0, 1'b0, 64'h0, 1'b0);
      step(32'h0, 1'b1, 32'h5A_8B_3C_C1 & ~32'h0040_0000, 1'b0, 64'h0, 1'b0);

      // R3: upper data bits ignore writes
      tag = "R3";
      step(32'h0, 1'b1, 32'h0, 1'b1, 64'hFFFF_1234_5678_9ABC, 1'b0);
      idle(32'h0);

      // R4: index above range counts nothing; mask selects bits
      tag = "R4";
      step(32'hFFFF_FFFF, 1'b1, 32'h0060_FF00, 1'b0, 64'h0, 1'b0);
      repeat (3) idle(32'hFFFF_FFFF);
      step(32'h0, 1'b1, 32'h0040_A503, 1'b0, 64'h0, 1'b0);
      repeat (4) idle($urandom);

      // R5: raw increment with threshold 0
      tag = "R5";
      for (int s = 0; s < NUM_EVT; s++) begin
         step(32'h0, 1'b1, 32'h0040_FF00 | s, 1'b0, 64'h0, 1'b0);
         repeat (5) idle($urandom);
      end

      // R6: threshold compare, 1 per qualifying cycle
      tag = "R6";
      step(32'h0, 1'b1, 32'h0440_FF01, 1'b0, 64'h0, 1'b0);
      idle(32'h0000_0F00); idle(32'h0000_0700); idle(32'h0000_FF00); idle(32'h0);
      repeat (6) idle($urandom);

      // R7: edge mode, non-zero and zero threshold
      tag = "R7";
      step(32'h0, 1'b1, 32'h0144_FF00, 1'b0, 64'h0, 1'b0);
      idle(32'h01); idle(32'h01); idle(32'h00); idle(32'h03); idle(32'h01);
      repeat (6) idle($urandom);
      step(32'h0, 1'b1, 32'h0044_FF00, 1'b0, 64'h0, 1'b0);
      idle(32'h0); idle(32'hFF); idle(32'h0); idle(32'hFF);

      // R8: disabled counter holds
      tag = "R8";
      step(32'h0, 1'b1, 32'h0000_FF00, 1'b0, 64'h0, 1'b0);
      repeat (4) idle(32'hFF);

      // R9: clear beats data write, data write beats counting
      tag = "R9";
      step(32'hFF, 1'b1, 32'h0040_FF00, 1'b1, 64'h77, 1'b0);
      step(32'hFF, 1'b0, 32'h0, 1'b1, 64'h1000, 1'b0);
      idle(32'hFF);
      step(32'hFF, 1'b1, 32'h0042_FF00, 1'b1, 64'h55, 1'b0);
      idle(32'hFF);

      // R10: wrap with and without overflow reporting
      tag = "R10";
      step(32'h0, 1'b1, 32'h0050_0300, 1'b1, 64'h0000_FFFF_FFFF_FFFD, 1'b0);
      idle(32'h03); idle(32'h03); idle(32'h03); idle(32'h03);
      step(32'h0, 1'b0, 32'h0, 1'b1, 64'h0000_FFFF_FFFF_FFFF, 1'b1);
      step(32'h0, 1'b1, 32'h0040_0300, 1'b0, 64'h0, 1'b0);
      idle(32'h01); idle(32'h0);

      // R11: sticky flag and simultaneous set/clear
      tag = "R11";
      step(32'h0, 1'b1, 32'h0050_0300, 1'b1, 64'h0000_FFFF_FFFF_FFFF, 1'b0);
      step(32'h01, 1'b0, 32'h0, 1'b0, 64'h0, 1'b0);
      repeat (3) idle(32'h0);
      step(32'h0, 1'b0, 32'h0, 1'b1, 64'h0000_FFFF_FFFF_FFFF, 1'b1);
      step(32'h01, 1'b0, 32'h0, 1'b0, 64'h0, 1'b1);
      step(32'h0, 1'b0, 32'h0, 1'b0, 64'h0, 1'b1);
      idle(32'h0);

      // mixed random traffic: R4 R5 R6 R7 R9 R11
      tag = "R4 R5 R6 R7 R9 R11 mix";
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r = $urandom;
         logic [31:0] cw = $urandom;
         cw[21] = (r[3:0] == 0);
         cw[7:0] = {6'h0, cw[1:0]};
         cw[31:24] = {5'h0, cw[26:24]};
         step($urandom, r[7:0] < 8, cw, r[15:8] < 4,
              {$urandom, 8'h0, 8'h0, r[31:16]}, r[23:20] == 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule